// File: doc/BRIEF.md
# Four-State Moore Sequence Machine

This block is a small Moore finite state machine that watches a single-bit input stream and produces a single-bit flag. The flag depends only on the current state, so it is stable for a whole clock period and never has a combinational path from the input. The state lives in a 2-bit register. A clock enable qualifies every update, and an asynchronous active-high reset returns the machine to its home state at any time.

Two of the four states cannot be reached from the home state by any input sequence. They can only be entered by loading the register directly, and once entered the machine drains back towards the home pair. The output decode maps any state code outside the defined set to a low flag.

Top module: `moore_seq_fsm`

## Requirements
- R1: While `rst` is high, the state is S1 (code 0) and `flagOut` is 1. This holds at once, without waiting for a clock edge.
- R2: State codes are S1=0, S2=1, S3=2, S4=3. `flagOut` is 1 in S1 and S4 and 0 in S2 and S3. Any other code gives 0.
- R3: In S1 with `en` high, a rising edge moves to S2 when `seqIn` is 1 and stays in S1 when `seqIn` is 0.
- R4: In S2 with `en` high, a rising edge moves to S1 when `seqIn` is 0 and stays in S2 when `seqIn` is 1.
- R5: In S3 with `en` high, a rising edge moves to S2 when `seqIn` is 0 and stays in S3 when `seqIn` is 1.
- R6: In S4 with `en` high, a rising edge moves to S1 when `seqIn` is 0 and to S3 when `seqIn` is 1.
- R7: When `en` is low at a rising edge, the state and `flagOut` keep their values whatever `seqIn` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high, returns to S1 |
| en | input | 1 | Clock enable for the state update |
| seqIn | input | 1 | Serial input bit sampled at the rising edge |
| flagOut | output | 1 | Moore output decoded from the current state |

## Verification
A wrong next state is visible on `flagOut` in the period after the faulty edge only when it swaps a high-flag state for a low one. A mistake between S2 and S3, or between S1 and S4, stays hidden until a later input drives the two states apart. The scoreboard therefore follows each forced entry into S3 or S4 with a short sequence that separates these pairs within two or three cycles. The bound checker looks at the state register and the next-state strobe directly, so it catches a wrong transition in the same cycle that it happens.

// File: rtl/moore_seq_pkg.sv
package moore_seq_pkg;
  localparam int STATE_W = 2;
  localparam int NUM_STATES = 1 << STATE_W;

  typedef enum logic [STATE_W-1:0] {
    ST_ONE   = 2'd0,
    ST_TWO   = 2'd1,
    ST_THREE = 2'd2,
    ST_FOUR  = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    seqState_e nextState;
  } seqStrobe_t;
endpackage

// File: rtl/moore_seq_ctrl.sv
module moore_seq_ctrl
  import moore_seq_pkg::*;
(
  input  logic       en,
  input  logic       seqIn,
  input  seqState_e  curState,
  output seqStrobe_t strobe
);
  always_comb begin
    strobe.load = en;
    case (curState)
      ST_ONE, ST_TWO: strobe.nextState = seqIn ? ST_TWO : ST_ONE;
      ST_THREE:       strobe.nextState = seqIn ? ST_THREE : ST_TWO;
      ST_FOUR:        strobe.nextState = seqIn ? ST_THREE : ST_ONE;
      default:        strobe.nextState = ST_ONE;
    endcase
  end
endmodule

// File: rtl/moore_seq_dp.sv
module moore_seq_dp
  import moore_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output seqState_e  stateQ,
  output logic       flagOut
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateQ <= ST_ONE;
    end else if (strobe.load) begin
      stateQ <= strobe.nextState;
    end
  end

  // Moore decode, undefined codes read as low
  always_comb begin
    case (stateQ)
      ST_ONE, ST_FOUR:  flagOut = 1'b1;
      ST_TWO, ST_THREE: flagOut = 1'b0;
      default:          flagOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/moore_seq_fsm.sv
module moore_seq_fsm
  import moore_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic seqIn,
  output logic flagOut
);
  seqStrobe_t strobe;
  seqState_e  stateQ;

  moore_seq_ctrl ctlI (
    .en       (en),
    .seqIn    (seqIn),
    .curState (stateQ),
    .strobe   (strobe)
  );

  moore_seq_dp dpI (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .stateQ  (stateQ),
    .flagOut (flagOut)
  );
endmodule

// File: rtl/moore_seq_chk.sv
module moore_seq_chk
  import moore_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       seqIn,
  input logic       flagOut,
  input seqState_e  stateQ,
  input seqStrobe_t strobe
);
  p_reset_home_r1: assert property (@(posedge clk)
    rst |-> (stateQ == ST_ONE && flagOut));

  p_low_states_r2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_TWO || stateQ == ST_THREE) |-> !flagOut);

  p_high_states_r2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ONE || stateQ == ST_FOUR) |-> flagOut);

  p_from_one_r3: assert property (@(posedge clk) disable iff (rst)
    (en && stateQ == ST_ONE) |-> strobe.nextState == (seqIn ? ST_TWO : ST_ONE));

  p_from_two_r4: assert property (@(posedge clk) disable iff (rst)
    (en && stateQ == ST_TWO) |-> strobe.nextState == (seqIn ? ST_TWO : ST_ONE));

  p_from_three_r5: assert property (@(posedge clk) disable iff (rst)
    (en && stateQ == ST_THREE) |-> strobe.nextState == (seqIn ? ST_THREE : ST_TWO));

  p_from_four_r6: assert property (@(posedge clk) disable iff (rst)
    (en && stateQ == ST_FOUR) |-> strobe.nextState == (seqIn ? ST_THREE : ST_ONE));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |-> !strobe.load);
endmodule

bind moore_seq_fsm moore_seq_chk chkI (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .seqIn   (seqIn),
  .flagOut (flagOut),
  .stateQ  (stateQ),
  .strobe  (strobe)
);

// File: tb/moore_seq_fsm_tb.sv
`timescale 1ns/1ps
module moore_seq_fsm_tb_top;
  import moore_seq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic seqIn = 1'b0;
  logic flagOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    bit    z;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  seqState_e model = ST_ONE;

  always #2.5 clk = ~clk;

  moore_seq_fsm dut_i (
    .clk(clk), .rst(rst), .en(en), .seqIn(seqIn), .flagOut(flagOut)
  );

  function automatic seqState_e nextOf(seqState_e s, bit a);
    case (s)
      ST_ONE, ST_TWO: return a ? ST_TWO : ST_ONE;
      ST_THREE:       return a ? ST_THREE : ST_TWO;
      default:        return a ? ST_THREE : ST_ONE;
    endcase
  endfunction

  function automatic bit zOf(seqState_e s);
    return (s == ST_ONE || s == ST_FOUR);
  endfunction

  task automatic checkNow(bit exp, string req);
    checks++;
    if (flagOut !== exp) begin
      fails++;
      $display("FAIL %s: flagOut=%0b expected %0b", req, flagOut, exp);
    end
  endtask

  // driver: one clock step, pushes expected output
  task automatic step(bit a, bit e, string req);
    expItem_t it;
    @(negedge clk);
    seqIn = a;
    en = e;
    if (e) model = nextOf(model, a);
    it.z = zOf(model);
    it.req = req;
    expQ.push_back(it);
  endtask

  // load an otherwise unreachable state directly
  task automatic forceState(seqState_e s, string req);
    @(negedge clk);
    en = 1'b0;
    force dut_i.dpI.stateQ = s;
    #0.1;
    release dut_i.dpI.stateQ;
    model = s;
    #0.1;
    checkNow(zOf(s), req);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checkNow(it.z, it.req);
      end
    end
  end

  initial begin
    #1;
    checkNow(1'b1, "R1 reset");
    repeat (2) @(negedge clk);
    rst = 1'b0;

    step(0, 1, "R3 S1 stay");
    step(1, 1, "R3 S1 to S2");
    step(1, 1, "R4 S2 stay");
    step(0, 1, "R4 S2 to S1");
    step(1, 1, "R3 S1 to S2");
    step(0, 0, "R7 hold S2");
    step(1, 0, "R7 hold S2");
    step(0, 1, "R4 S2 to S1");
    step(1, 0, "R7 hold S1");

    forceState(ST_THREE, "R2 S3 low");
    step(1, 1, "R5 S3 stay");
    step(0, 1, "R5 S3 to S2");
    step(0, 1, "R4 S2 to S1");

    forceState(ST_FOUR, "R2 S4 high");
    step(0, 1, "R6 S4 to S1");
    step(1, 1, "R3 S1 to S2");

    forceState(ST_FOUR, "R2 S4 high");
    step(1, 1, "R6 S4 to S3");
    step(1, 1, "R5 S3 stay");
    step(0, 1, "R5 S3 to S2");
    step(0, 1, "R4 S2 to S1");

    forceState(ST_FOUR, "R2 S4 high");
    step(1, 0, "R7 hold S4");
    step(0, 0, "R7 hold S4");
    step(1, 1, "R6 S4 to S3");

    forceState(ST_THREE, "R2 S3 low");
    step(0, 0, "R7 hold S3");
    step(1, 1, "R5 S3 stay");

    // pseudo-random walk
    begin
      logic [7:0] lfsr = 8'hA5;
      for (int i = 0; i < 48; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(lfsr[0], lfsr[2] | lfsr[5], "R3 R4 R5 R7 walk");
      end
    end

    // async reset in the middle of a run
    step(1, 1, "R3 R4 before reset");
    @(negedge clk);
    #2;
    expQ.delete();
    rst = 1'b1;
    #0.2;
    checkNow(1'b1, "R1 async reset");
    model = ST_ONE;
    @(negedge clk);
    rst = 1'b0;
    step(1, 1, "R3 after reset");
    step(0, 1, "R4 after reset");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule